// File: doc/BRIEF.md
# Radix-16 Sequential Significand Multiplier

This block multiplies two 53-bit unsigned significands over several clock cycles. One multiplier digit of four bits is retired per cycle. The digit selects up to four shifted copies of the multiplicand, and those copies are added into a 64-bit accumulator after the accumulator has moved down by one digit. The four bits that drop off the bottom of the accumulator on each step are folded into a sticky flag.

Once all the digits are retired, the block normalizes the product so that its leading one sits in the top significand position. It adjusts the caller's exponent to match the shifts it made. It then returns a 53-bit significand together with a guard bit and a sticky bit, which a downstream rounding stage can use.

The caller pulses `start` with both operands and the pre-summed exponent. The caller then waits for the one-cycle `done` pulse. Special operands (NaN, infinity) and rounding are handled elsewhere.

Top module: `r16_sig_multiplier`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `busy`, `done`, `sig_o`, `guard_o`, `sticky_o` and `exp_o` are all zero.
- R2: A `start` seen high while `busy` is low captures `mcand_i`, `mplr_i` and `exp_i`, and `busy` is high in the next cycle.
- R3: A `start` seen while `busy` is high has no effect: the run in flight finishes with its original operands and its original timing.
- R4: `done` is high for exactly one cycle per accepted start, and `busy` is low in that cycle. A new `start` in that same cycle is accepted.
- R5: When both operands have bit 52 set, `done` is high in the 16th clock cycle after the edge that sampled `start`.
- R6: Let P be the exact 106-bit product of two operands that have bit 52 set. If P bit 105 is set, `sig_o` = P[105:53] and `exp_o` = `exp_i` + 1. Otherwise `sig_o` = P[104:52] and `exp_o` = `exp_i`.
- R7: `guard_o` is the product bit directly below the lowest bit of `sig_o`. `sticky_o` is the OR of every product bit below the guard bit.
- R8: An operand without bit 52 set gives a result that is shifted left, one cycle per position, until bit 52 of `sig_o` is set. `exp_o` drops by one for each such shift, and `done` is delayed by one cycle per shift. Product bits of weight below 2^45 contribute only to `sticky_o`, and the positions vacated by these shifts are filled with zeros.
- R9: A zero operand gives `sig_o` = 0, `guard_o` = 0, `sticky_o` = 0 and `exp_o` = `exp_i`, with the latency of R5.
- R10: `sig_o`, `guard_o`, `sticky_o` and `exp_o` change only in a cycle in which `done` is high. They hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply; ignored while busy |
| mcand_i | input | 53 | Multiplicand significand |
| mplr_i | input | 53 | Multiplier significand |
| exp_i | input | 13 | Signed pre-summed exponent |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse: results updated |
| sig_o | output | 53 | Normalized product significand |
| guard_o | output | 1 | First bit below the significand |
| sticky_o | output | 1 | OR of all bits below the guard bit |
| exp_o | output | 13 | Signed adjusted exponent |

## Verification
Two events can land in the same cycle: the completion pulse of one run and the `start` of the next. The bench raises `start` in exactly the cycle in which `done` is visible, for a chain of back-to-back operations. It then checks that each run's result and its 16-cycle latency match the wide-integer reference. The second collision is a `start` arriving in the middle of a run, with different operands. It is judged by checking that the result and the timing still belong to the first operands, and that no extra `done` pulse follows.

// File: rtl/r16mul_pkg.sv
package r16mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MUL   = 2'd1,
    ST_ALIGN = 2'd2,
    ST_NORM  = 2'd3
  } r16_state_e;
endpackage

// File: rtl/r16_digit_adder.sv
// Adds up to RADIX_BITS shifted copies of the multiplicand onto a base value,
// one copy per set bit of the digit.
module r16_digit_adder #(
  parameter int ACC_W      = 64,
  parameter int RADIX_BITS = 4
) (
  input  logic [ACC_W-1:0]      base_i,
  input  logic [ACC_W-1:0]      mcand_i,
  input  logic [RADIX_BITS-1:0] digit_i,
  output logic [ACC_W-1:0]      sum_o
);
  logic [ACC_W-1:0] term [RADIX_BITS];

  for (genvar k = 0; k < RADIX_BITS; k++) begin : g_term
    assign term[k] = digit_i[k] ? (mcand_i << k) : '0;
  end

  always_comb begin
    sum_o = base_i;
    for (int k = 0; k < RADIX_BITS; k++) begin
      sum_o = sum_o + term[k];
    end
  end
endmodule

// File: rtl/r16_result_slice.sv
// Splits a normalized accumulator into significand, guard and low-sticky.
module r16_result_slice #(
  parameter int SIG_W = 53,
  parameter int TOP   = 60
) (
  input  logic [TOP:0]       acc_i,
  output logic [SIG_W-1:0]   sig_o,
  output logic               guard_o,
  output logic               low_nz_o
);
  localparam int GPOS = TOP - SIG_W;

  assign sig_o    = acc_i[TOP -: SIG_W];
  assign guard_o  = acc_i[GPOS];
  assign low_nz_o = |acc_i[GPOS-1:0];
endmodule

// File: rtl/r16_sig_multiplier.sv
module r16_sig_multiplier
  import r16mul_pkg::*;
#(
  parameter int SIG_W      = 53,
  parameter int RADIX_BITS = 4,
  parameter int PRE_SHIFT  = 7,
  parameter int EXP_W      = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [SIG_W-1:0]        mcand_i,
  input  logic [SIG_W-1:0]        mplr_i,
  input  logic signed [EXP_W-1:0] exp_i,
  output logic                    busy,
  output logic                    done,
  output logic [SIG_W-1:0]        sig_o,
  output logic                    guard_o,
  output logic                    sticky_o,
  output logic signed [EXP_W-1:0] exp_o
);
  localparam int ITERS = (SIG_W + RADIX_BITS - 1) / RADIX_BITS;
  localparam int MC_W  = SIG_W + PRE_SHIFT;
  localparam int ACC_W = MC_W + RADIX_BITS;
  localparam int MP_W  = ITERS * RADIX_BITS;
  localparam int TOP   = 2 * SIG_W - 1 + PRE_SHIFT - RADIX_BITS * (ITERS - 1);
  localparam int CNT_W = $clog2(ITERS + 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ITERS - 1);
  localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(1);

  r16_state_e               state;
  logic [CNT_W-1:0]         iter;
  logic [MC_W-1:0]          mcand_r;
  logic [MP_W-1:0]          mplr_r;
  logic [ACC_W-1:0]         acc;
  logic                     stk;
  logic signed [EXP_W-1:0]  exp_r;

  logic [ACC_W-1:0]         acc_next;
  logic [SIG_W-1:0]         slice_sig;
  logic                     slice_guard;
  logic                     slice_low;

  r16_digit_adder #(
    .ACC_W      (ACC_W),
    .RADIX_BITS (RADIX_BITS)
  ) u_add (
    .base_i  (acc >> RADIX_BITS),
    .mcand_i (ACC_W'(mcand_r)),
    .digit_i (mplr_r[RADIX_BITS-1:0]),
    .sum_o   (acc_next)
  );

  r16_result_slice #(
    .SIG_W (SIG_W),
    .TOP   (TOP)
  ) u_slice (
    .acc_i    (acc[TOP:0]),
    .sig_o    (slice_sig),
    .guard_o  (slice_guard),
    .low_nz_o (slice_low)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      iter     <= '0;
      mcand_r  <= '0;
      mplr_r   <= '0;
      acc      <= '0;
      stk      <= 1'b0;
      exp_r    <= '0;
      done     <= 1'b0;
      sig_o    <= '0;
      guard_o  <= 1'b0;
      sticky_o <= 1'b0;
      exp_o    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            mcand_r <= {mcand_i, {PRE_SHIFT{1'b0}}};
            mplr_r  <= MP_W'(mplr_i);
            acc     <= '0;
            stk     <= 1'b0;
            exp_r   <= exp_i;
            iter    <= '0;
            state   <= ST_MUL;
          end
        end
        ST_MUL: begin
          stk    <= stk | (|acc[RADIX_BITS-1:0]);
          acc    <= acc_next;
          mplr_r <= mplr_r >> RADIX_BITS;
          iter   <= iter + CNT_ONE;
          if (iter == CNT_LAST) state <= ST_ALIGN;
        end
        ST_ALIGN: begin
          if (acc[TOP]) exp_r <= exp_r + EXP_ONE;
          else          acc   <= acc << 1;
          state <= ST_NORM;
        end
        default: begin
          if (!acc[TOP] && (acc != '0)) begin
            acc   <= acc << 1;
            exp_r <= exp_r - EXP_ONE;
          end else begin
            sig_o    <= slice_sig;
            guard_o  <= slice_guard;
            sticky_o <= stk | slice_low;
            exp_o    <= exp_r;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/r16_sig_multiplier_chk.sv
module r16_sig_multiplier_chk #(
  parameter int SIG_W = 53,
  parameter int MC_W  = 60,
  parameter int ITERS = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [SIG_W-1:0] sig_o,
  input logic [MC_W-1:0]  mcand_r
);
  logic [15:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_len <= busy ? 16'd1 : 16'd0;
    else if (run_len != 16'hFFFF) run_len <= run_len + 16'd1;
  end

  // R2: accepted start raises busy
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R3: captured operands stay put for the whole run
  a_r3_ignore_start: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mcand_r));

  // R4: done is a single-cycle pulse outside busy
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R5: no result before all digits and the align step are through
  a_r5_min_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len >= 16'(ITERS + 2)));

  // R8: a delivered significand is normalized or zero
  a_r8_normalized: assert property (@(posedge clk) disable iff (rst)
    done |-> (sig_o[SIG_W-1] || (sig_o == '0)));

  // R10: results move only with done
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(sig_o));
endmodule

bind r16_sig_multiplier r16_sig_multiplier_chk #(
  .SIG_W (SIG_W),
  .MC_W  (MC_W),
  .ITERS (ITERS)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .sig_o   (sig_o),
  .mcand_r (mcand_r)
);

// File: tb/r16_sig_multiplier_tb_top.sv
`timescale 1ns/1ps
module r16_sig_multiplier_tb_top;
  localparam real CYC = 10.0;

  logic               clk = 1'b0;
  logic               rst;
  logic               start;
  logic [52:0]        mcand_i, mplr_i;
  logic signed [12:0] exp_i;
  logic               busy, done, guard_o, sticky_o;
  logic [52:0]        sig_o;
  logic signed [12:0] exp_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CYC/2) clk = ~clk;

  r16_sig_multiplier dut_i (
    .clk(clk), .rst(rst), .start(start),
    .mcand_i(mcand_i), .mplr_i(mplr_i), .exp_i(exp_i),
    .busy(busy), .done(done), .sig_o(sig_o),
    .guard_o(guard_o), .sticky_o(sticky_o), .exp_o(exp_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference: exact product truncated at weight 2^45, then normalized.
  task automatic ref_calc(input logic [52:0] a, input logic [52:0] b,
                          input logic signed [12:0] e,
                          output logic [52:0] s, output logic g, output logic st,
                          output logic signed [12:0] eo, output int shifts);
    logic [105:0] p;
    logic [60:0]  acc;
    p  = {53'd0, a} * {53'd0, b};
    acc = p[105:45];
    st = |p[44:0];
    eo = e;
    shifts = 0;
    if (acc[60]) eo = eo + 13'sd1;
    else acc = acc << 1;
    for (int i = 0; i < 128; i++) begin
      if (!acc[60] && acc != '0) begin
        acc = acc << 1; eo = eo - 13'sd1; shifts++;
      end
    end
    g  = acc[7];
    st = st | (|acc[6:0]);
    s  = acc[60:8];
  endtask

  // Assumes the caller is at a falling edge; start is held for one edge.
  task automatic run_op(input logic [52:0] a, input logic [52:0] b,
                        input logic signed [12:0] e, input string req,
                        input bit poke_mid);
    logic [52:0] es; logic eg, est; logic signed [12:0] ee; int sh; int lat;
    ref_calc(a, b, e, es, eg, est, ee, sh);
    mcand_i = a; mplr_i = b; exp_i = e; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    lat = 0;
    forever begin
      @(posedge clk); lat++;
      if (poke_mid && lat == 5) begin
        #1 mcand_i = ~a; mplr_i = ~b; exp_i = -e; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (done || lat > 400) break;
    end
    check(done, req, "done seen", {63'd0, done}, 64'd1);
    check(sig_o == es, req, "significand", {11'd0, sig_o}, {11'd0, es});
    check(guard_o == eg, "R7", "guard", {63'd0, guard_o}, {63'd0, eg});
    check(sticky_o == est, "R7", "sticky", {63'd0, sticky_o}, {63'd0, est});
    check(exp_o == ee, req, "exponent", 64'(exp_o), 64'(ee));
    check(lat == 16 + sh, (sh == 0) ? "R5" : "R8", "latency",
          64'(lat), 64'(16 + sh));
    check(!busy, "R4", "busy low with done", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_reset;
    rst = 1'b1; start = 1'b0; mcand_i = '0; mplr_i = '0; exp_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !done, "R1", "busy/done in reset", {62'd0, busy, done}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && sig_o == '0 && !guard_o && !sticky_o && exp_o == '0,
          "R1", "outputs after reset", {11'd0, sig_o}, 64'd0);
  endtask

  task automatic t_directed;
    run_op(53'h10_0000_0000_0000, 53'h10_0000_0000_0000, 13'sd100, "R6", 1'b0);
    run_op(53'h1F_FFFF_FFFF_FFFF, 53'h1F_FFFF_FFFF_FFFF, -13'sd20, "R6", 1'b0);
    run_op(53'h18_0000_0000_0000, 53'h10_0000_0000_0001, 13'sd3, "R6", 1'b0);
    run_op(53'h10_0000_0000_0001, 53'h10_0000_0000_0001, 13'sd0, "R7", 1'b0);
    run_op(53'h1A_5A5A_5A5A_5A5B, 53'h13_3333_3333_3333, 13'sd7, "R7", 1'b0);
  endtask

  task automatic t_unnormalized;
    run_op(53'h1, 53'h1F_0000_0000_00F1, 13'sd60, "R8", 1'b0);
    run_op(53'h0_0000_8000_0003, 53'h10_0000_0000_0001, -13'sd5, "R8", 1'b0);
  endtask

  task automatic t_zero;
    run_op(53'h0, 53'h1F_FFFF_FFFF_FFFF, 13'sd42, "R9", 1'b0);
  endtask

  task automatic t_busy_start;
    run_op(53'h15_5555_5555_5555, 53'h1C_CCCC_CCCC_CCCD, 13'sd9, "R3", 1'b1);
    repeat (20) begin
      @(negedge clk);
      check(!done && !busy, "R3", "no run from mid-flight start",
            {62'd0, done, busy}, 64'd0);
    end
  endtask

  task automatic t_hold;
    logic [52:0] s0; logic signed [12:0] e0;
    run_op(53'h1E_1234_5678_9ABC, 53'h11_1111_2222_3333, 13'sd1, "R6", 1'b0);
    s0 = sig_o; e0 = exp_o;
    mcand_i = '1; mplr_i = '1; exp_i = 13'sd77;
    repeat (6) @(negedge clk);
    check(sig_o == s0 && exp_o == e0 && !done, "R10", "outputs held",
          {11'd0, sig_o}, {11'd0, s0});
  endtask

  task automatic t_back_to_back;
    // each run_op starts in the very cycle the previous done is visible
    for (int i = 0; i < 30; i++) begin
      logic [52:0] a, b;
      a = {1'b1, $urandom(), $urandom()} ;
      b = {1'b1, $urandom(), $urandom()} ;
      run_op(a, b, 13'(i * 37 - 500), "R4", 1'b0);
    end
  endtask

  initial begin
    #(CYC * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_directed();
    t_unnormalized();
    t_zero();
    t_busy_start();
    t_hold();
    t_back_to_back();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule